// File: doc/BRIEF.md
# Registered Bidirectional Bus Transceiver

This block joins two bidirectional data buses, side A and side B, each of parameter width. Every side has a storage register with its own clock. The A register samples the A side on each rising edge of the A-side clock, and the B register samples the B side on each rising edge of the B-side clock. Sampling happens on every edge, whatever the drive controls are doing. An active-low output enable and a direction input decide which side, if either, is driven. A select input for each direction then decides what that side carries: the live value arriving on the opposite side, or the value held in the opposite side's register.

Each pad is modelled as three separate signals: an input vector, an output vector and a single output-enable bit. The pad driver outside the block combines them. An elaboration parameter chooses between a pass-through data path and a complementing one. Both registers clear asynchronously on an active-low reset.

A register can be clocked while its own side is being driven. In that case it samples whatever its input vector shows at that moment. This is implementation-defined, and normally it is the loopback of the driven value.

Top module: `bus_xcvr_reg`

## Requirements
- R1: While rst_n is low, both registers clear to all zeros. After release, a stored value is read out as zero, or as all ones when INVERT is 1.
- R2: On each rising edge of clk_ab, the A register loads a_in. This happens for every combination of oe_n and dir, including oe_n high and dir high.
- R3: On each rising edge of clk_ba, the B register loads b_in. This happens for every combination of oe_n and dir, including oe_n low and dir low.
- R4: When oe_n is 1, both a_oe and b_oe are 0. With no clock edges, changes on a_in and b_in leave both stored values unchanged.
- R5: When oe_n is 0 and dir is 0, a_oe is 1 and b_oe is 0. With sel_ba at 0, a_out follows b_in live, and sel_ab has no effect.
- R6: When oe_n is 0, dir is 0 and sel_ba is 1, a_out shows the B register contents.
- R7: When oe_n is 0 and dir is 1, b_oe is 1 and a_oe is 0. With sel_ab at 0, b_out follows a_in live, and sel_ba has no effect.
- R8: When oe_n is 0, dir is 1 and sel_ab is 1, b_out shows the A register contents.
- R9: When INVERT is 1, the driven side carries the bitwise complement of the selected data. When INVERT is 0, the data passes unchanged.
- R10: If the A register is clocked while side A is driven, it stores a_in. When a_in is looped back from a_out, that is the driven word.
- R11: A side whose output enable is 0 presents all zeros on its output vector.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_ab | input | 1 | Rising edge loads the A register from a_in |
| clk_ba | input | 1 | Rising edge loads the B register from b_in |
| rst_n | input | 1 | Asynchronous active-low clear of both registers |
| oe_n | input | 1 | Active-low drive enable for both sides |
| dir | input | 1 | 0 drives side A, 1 drives side B |
| sel_ab | input | 1 | Source for side B: 0 live a_in, 1 stored A |
| sel_ba | input | 1 | Source for side A: 0 live b_in, 1 stored B |
| a_in | input | WIDTH | Value seen at the A pads |
| a_out | output | WIDTH | Value to drive onto the A pads |
| a_oe | output | 1 | Drive enable for the A pads |
| b_in | input | WIDTH | Value seen at the B pads |
| b_out | output | WIDTH | Value to drive onto the B pads |
| b_oe | output | 1 | Drive enable for the B pads |

## Verification
The bench first loads the two registers with distinct, asymmetric words: 3C on side A and A5 on side B. Those stored words can then never be mistaken for the live words applied to the pads. A table then walks every oe_n and dir pairing with both select settings. It includes the cross cases where the unused select is set opposite to the used one. These rows separate live from stored sourcing, the choice of driven side, and the zeroing of an idle side. A pass-through instance and a complementing instance run side by side on the same stimulus, so any mix-up of the inversion shows as a mismatch between them. Directed steps then check the reset contents, capture while isolated, hold without clocks, and loopback capture while driving.

// File: rtl/xcvr_pkg.sv
package xcvr_pkg;
   typedef enum logic [1:0] {
      DRV_NONE = 2'b00,
      DRV_A    = 2'b01,
      DRV_B    = 2'b10
   } drive_e;

   function automatic drive_e decode_drive(input logic oe_n, input logic dir);
      if (oe_n)
         return DRV_NONE;
      else if (dir)
         return DRV_B;
      else
         return DRV_A;
   endfunction
endpackage

// File: rtl/xcvr_store_reg.sv
module xcvr_store_reg #(
   parameter int WIDTH = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);
   localparam logic [WIDTH-1:0] CLEAR = '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         q <= CLEAR;
      else
         q <= d;
   end
endmodule

// File: rtl/xcvr_path_mux.sv
module xcvr_path_mux #(
   parameter int WIDTH  = 8,
   parameter bit INVERT = 1'b0
) (
   input  logic [WIDTH-1:0] live,
   input  logic [WIDTH-1:0] stored,
   input  logic             use_stored,
   input  logic             enable,
   output logic [WIDTH-1:0] dout
);
   logic [WIDTH-1:0] picked;
   logic [WIDTH-1:0] shaped;

   always_comb picked = use_stored ? stored : live;

   generate
      if (INVERT) begin : g_inv
         always_comb shaped = ~picked;
      end else begin : g_pass
         always_comb shaped = picked;
      end
   endgenerate

   always_comb dout = enable ? shaped : '0;
endmodule

// File: rtl/xcvr_drive_ctl.sv
module xcvr_drive_ctl
   import xcvr_pkg::*;
(
   input  logic oe_n,
   input  logic dir,
   output logic a_en,
   output logic b_en
);
   drive_e mode;

   always_comb begin
      mode = decode_drive(oe_n, dir);
      a_en = (mode == DRV_A);
      b_en = (mode == DRV_B);
   end
endmodule

// File: rtl/bus_xcvr_reg.sv
module bus_xcvr_reg #(
   parameter int WIDTH  = 8,
   parameter bit INVERT = 1'b0
) (
   input  logic             clk_ab,
   input  logic             clk_ba,
   input  logic             rst_n,
   input  logic             oe_n,
   input  logic             dir,
   input  logic             sel_ab,
   input  logic             sel_ba,
   input  logic [WIDTH-1:0] a_in,
   output logic [WIDTH-1:0] a_out,
   output logic             a_oe,
   input  logic [WIDTH-1:0] b_in,
   output logic [WIDTH-1:0] b_out,
   output logic             b_oe
);
   generate
      if (WIDTH < 1) begin : g_bad_width
         $error("bus_xcvr_reg: WIDTH must be at least 1");
      end
   endgenerate

   logic [WIDTH-1:0] a_store;
   logic [WIDTH-1:0] b_store;
   logic             a_en;
   logic             b_en;

   xcvr_store_reg #(.WIDTH(WIDTH)) u_a_reg (
      .clk   (clk_ab),
      .rst_n (rst_n),
      .d     (a_in),
      .q     (a_store)
   );

   xcvr_store_reg #(.WIDTH(WIDTH)) u_b_reg (
      .clk   (clk_ba),
      .rst_n (rst_n),
      .d     (b_in),
      .q     (b_store)
   );

   xcvr_drive_ctl u_ctl (
      .oe_n (oe_n),
      .dir  (dir),
      .a_en (a_en),
      .b_en (b_en)
   );

   xcvr_path_mux #(.WIDTH(WIDTH), .INVERT(INVERT)) u_to_a (
      .live       (b_in),
      .stored     (b_store),
      .use_stored (sel_ba),
      .enable     (a_en),
      .dout       (a_out)
   );

   xcvr_path_mux #(.WIDTH(WIDTH), .INVERT(INVERT)) u_to_b (
      .live       (a_in),
      .stored     (a_store),
      .use_stored (sel_ab),
      .enable     (b_en),
      .dout       (b_out)
   );

   assign a_oe = a_en;
   assign b_oe = b_en;
endmodule

// File: rtl/bus_xcvr_reg_chk.sv
module bus_xcvr_reg_chk #(
   parameter int WIDTH  = 8,
   parameter bit INVERT = 1'b0
) (
   input logic             clk_ab,
   input logic             clk_ba,
   input logic             rst_n,
   input logic             oe_n,
   input logic             dir,
   input logic             sel_ab,
   input logic [WIDTH-1:0] a_in,
   input logic [WIDTH-1:0] b_in,
   input logic [WIDTH-1:0] b_out,
   input logic             a_oe,
   input logic             b_oe,
   input logic [WIDTH-1:0] a_store,
   input logic [WIDTH-1:0] b_store
);
   p_a_capture_r2: assert property (@(posedge clk_ab) disable iff (!rst_n)
      1'b1 |=> (a_store == $past(a_in)));

   p_b_capture_r3: assert property (@(posedge clk_ba) disable iff (!rst_n)
      1'b1 |=> (b_store == $past(b_in)));

   p_isolate_r4: assert property (@(posedge clk_ab) disable iff (!rst_n)
      oe_n |-> (!a_oe && !b_oe));

   p_drive_a_r5: assert property (@(posedge clk_ba) disable iff (!rst_n)
      (!oe_n && !dir) |-> (a_oe && !b_oe));

   p_live_b_r7: assert property (@(posedge clk_ab) disable iff (!rst_n)
      (!oe_n && dir && !sel_ab) |-> (b_out == (INVERT ? ~a_in : a_in)));

   p_idle_zero_r11: assert property (@(posedge clk_ba) disable iff (!rst_n)
      !b_oe |-> (b_out == '0));
endmodule

bind bus_xcvr_reg bus_xcvr_reg_chk #(.WIDTH(WIDTH), .INVERT(INVERT)) u_chk (
   .clk_ab  (clk_ab),
   .clk_ba  (clk_ba),
   .rst_n   (rst_n),
   .oe_n    (oe_n),
   .dir     (dir),
   .sel_ab  (sel_ab),
   .a_in    (a_in),
   .b_in    (b_in),
   .b_out   (b_out),
   .a_oe    (a_oe),
   .b_oe    (b_oe),
   .a_store (a_store),
   .b_store (b_store)
);

// File: tb/test_bus_xcvr_reg.sv
module test_bus_xcvr_reg;
   logic clk = 1'b0;
   always #4 clk = ~clk;

   logic       clk_ab = 1'b0, clk_ba = 1'b0, rst_n = 1'b0;
   logic       oe_n = 1'b1, dir = 1'b0, sel_ab = 1'b0, sel_ba = 1'b0;
   logic       loop_en = 1'b0;
   logic [7:0] a_drv = 8'h00, b_in = 8'h00;
   logic [7:0] a_in_p, a_in_i;
   logic [7:0] a_out_p, b_out_p, a_out_i, b_out_i;
   logic       a_oe_p, b_oe_p, a_oe_i, b_oe_i;

   int errors = 0;
   int checks = 0;
   int cyc = 0;

   assign a_in_p = (loop_en && a_oe_p) ? a_out_p : a_drv;
   assign a_in_i = (loop_en && a_oe_i) ? a_out_i : a_drv;

   bus_xcvr_reg #(.WIDTH(8), .INVERT(1'b0)) i_bus_xcvr_reg (
      .clk_ab(clk_ab), .clk_ba(clk_ba), .rst_n(rst_n), .oe_n(oe_n), .dir(dir),
      .sel_ab(sel_ab), .sel_ba(sel_ba), .a_in(a_in_p), .a_out(a_out_p),
      .a_oe(a_oe_p), .b_in(b_in), .b_out(b_out_p), .b_oe(b_oe_p));

   bus_xcvr_reg #(.WIDTH(8), .INVERT(1'b1)) i_bus_xcvr_reg_inv (
      .clk_ab(clk_ab), .clk_ba(clk_ba), .rst_n(rst_n), .oe_n(oe_n), .dir(dir),
      .sel_ab(sel_ab), .sel_ba(sel_ba), .a_in(a_in_i), .a_out(a_out_i),
      .a_oe(a_oe_i), .b_in(b_in), .b_out(b_out_i), .b_oe(b_oe_i));

   task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s: got %h expected %h", req, got, exp);
      end
   endtask

   task automatic pulse_ab();
      #2 clk_ab = 1'b1;
      #3 clk_ab = 1'b0;
      #1;
   endtask

   task automatic pulse_ba();
      #2 clk_ba = 1'b1;
      #3 clk_ba = 1'b0;
      #1;
   endtask

   task automatic set_ctl(input logic o, input logic d, input logic sab, input logic sba);
      oe_n = o; dir = d; sel_ab = sab; sel_ba = sba;
      #1;
   endtask

   // row: {oe_n, dir, sel_ab, sel_ba, a_in, b_in, a_oe, b_oe, a_out, b_out}
   // stored A = 3C, stored B = A5 while the table runs; pass-through expectations
   localparam logic [37:0] VEC [0:7] = '{
      {4'b1000, 8'h11, 8'h22, 2'b00, 8'h00, 8'h00},  // R4 R11
      {4'b1111, 8'h11, 8'h22, 2'b00, 8'h00, 8'h00},  // R4 R11
      {4'b0000, 8'h55, 8'hC3, 2'b10, 8'hC3, 8'h00},  // R5 live
      {4'b0011, 8'h55, 8'hC3, 2'b10, 8'hA5, 8'h00},  // R6 stored
      {4'b0100, 8'h7E, 8'h81, 2'b01, 8'h00, 8'h7E},  // R7 live
      {4'b0111, 8'h7E, 8'h81, 2'b01, 8'h00, 8'h3C},  // R8 stored
      {4'b0010, 8'hF0, 8'h0F, 2'b10, 8'h0F, 8'h00},  // R5 sel_ab ignored
      {4'b0101, 8'hF0, 8'h0F, 2'b01, 8'h00, 8'hF0}   // R7 sel_ba ignored
   };

   always @(posedge clk) begin
      cyc++;
      if (cyc == 100000) begin
         errors++;
         checks++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      #10 rst_n = 1'b1;
      #2;
      // R1: reset contents seen through the stored paths
      set_ctl(1'b0, 1'b1, 1'b1, 1'b0);
      check("R1 stored A after reset", b_out_p, 8'h00);
      check("R1 R9 stored A after reset inv", b_out_i, 8'hFF);
      set_ctl(1'b0, 1'b0, 1'b0, 1'b1);
      check("R1 stored B after reset", a_out_p, 8'h00);

      // R2: A captured while B side driven; R3: B captured while A side driven
      set_ctl(1'b0, 1'b1, 1'b0, 1'b0);
      a_drv = 8'h3C;
      pulse_ab();
      set_ctl(1'b0, 1'b0, 1'b0, 1'b0);
      b_in = 8'hA5;
      pulse_ba();
      set_ctl(1'b0, 1'b1, 1'b1, 1'b0);
      check("R2 A captured with dir high", b_out_p, 8'h3C);
      set_ctl(1'b0, 1'b0, 1'b0, 1'b1);
      check("R3 B captured with A driven", a_out_p, 8'hA5);
      check("R3 R9 B captured inv", a_out_i, 8'h5A);

      for (int i = 0; i < 8; i++) begin
         logic [37:0] v;
         v = VEC[i];
         a_drv = v[33:26];
         b_in  = v[25:18];
         set_ctl(v[37], v[36], v[35], v[34]);
         check($sformatf("R4 R5 R7 row %0d a_oe", i), {7'b0, a_oe_p}, {7'b0, v[17]});
         check($sformatf("R4 R5 R7 row %0d b_oe", i), {7'b0, b_oe_p}, {7'b0, v[16]});
         check($sformatf("R5 R6 R11 row %0d a_out", i), a_out_p, v[15:8]);
         check($sformatf("R7 R8 R11 row %0d b_out", i), b_out_p, v[7:0]);
         check($sformatf("R9 row %0d a_out inv", i), a_out_i, v[17] ? ~v[15:8] : 8'h00);
         check($sformatf("R9 row %0d b_out inv", i), b_out_i, v[16] ? ~v[7:0] : 8'h00);
      end

      // R4: hold without clocks while isolated
      set_ctl(1'b1, 1'b0, 1'b0, 1'b0);
      a_drv = 8'h99; b_in = 8'h66;
      #5;
      set_ctl(1'b0, 1'b1, 1'b1, 1'b0);
      check("R4 A held", b_out_p, 8'h3C);
      set_ctl(1'b0, 1'b0, 1'b0, 1'b1);
      check("R4 B held", a_out_p, 8'hA5);

      // R2: capture while isolated
      set_ctl(1'b1, 1'b1, 1'b1, 1'b1);
      a_drv = 8'hE7;
      pulse_ab();
      set_ctl(1'b0, 1'b1, 1'b1, 1'b0);
      check("R2 A captured while isolated", b_out_p, 8'hE7);

      // R10: A clocked while side A driven, loopback on a_in
      set_ctl(1'b0, 1'b0, 1'b0, 1'b0);
      b_in = 8'h5A;
      loop_en = 1'b1;
      #1;
      pulse_ab();
      loop_en = 1'b0;
      set_ctl(1'b0, 1'b1, 1'b1, 1'b0);
      check("R10 loopback capture", b_out_p, 8'h5A);
      check("R10 R9 loopback capture inv", b_out_i, 8'h5A);

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule